// File: doc/BRIEF.md
# Banked Register Bus Write Sequencer

This block lets on-chip logic write registers in a peripheral that sits on a simple asynchronous parallel bus. The peripheral's register window has only sixteen locations. A bank-select register at window offset 0xE picks which set of registers the other offsets reach. A requester presents a bank number, a 4-bit register offset and a data word through a ready/valid handshake. The sequencer turns this into one or two strobed bus writes. When the peripheral may be on another bank, it first writes the bank-select register and then writes the target register.

Each bus write has two phases, both counted in clock cycles. In the first phase the write strobe is driven low while address and data are valid. In the second phase the strobe is back high while address and data stay unchanged. The data output enable is high only while a write cycle is in progress, so the bus is released between writes. The sequencer remembers the last bank it wrote and leaves out the bank-select write when the requested bank is already selected.

After every reset, and before any request is accepted, a fixed start-up script runs. It selects bank 0 and then sets the receive-enable bit of the peripheral's receive control register. The data path defaults to 32 bits; setting `DATA_W` to 16 gives the narrow variant.

Top module: `bank_wr_seq`

## Requirements
- R1: While reset is held, the write strobe `bus_wr_n` is 1, `bus_data_oe` is 0 and `req_ready` is 0.
- R2: After reset is released, the first two bus writes are 0 to address 0x30E and then 0x0001 (bit 0 = receive enable) to address 0x304. No request is accepted before both have completed.
- R3: Every bus address is the 12-bit base 0x300 plus the 4-bit register offset, so the bank-select register is at 0x30E.
- R4: In each write, `bus_wr_n` is low for exactly `LOW_CYC` cycles and then high for exactly `HIGH_CYC` cycles, with `bus_data_oe` high in both phases. Address and data hold steady for the whole write. `bus_data_oe` is low for at least one cycle between consecutive writes.
- R5: When a request's bank differs from the remembered bank, or no bank is remembered, the sequencer first writes the bank number, zero-extended, to offset 0xE, and then writes the data to the requested offset.
- R6: When a request's bank equals the remembered bank, only the target write occurs.
- R7: A request whose offset is 0xE produces a single write of its data to 0x30E, whatever its bank field. The remembered bank then becomes the low `BANK_W` bits of that data.
- R8: `req_ready` is 1 only while the sequencer is idle with no write in progress. A request held valid while the sequencer is busy waits, and `busy` is 1 in the cycle after an accepted request.
- R9: `done` pulses high for exactly one cycle when a request's target write has completed, and `req_ready` returns to 1 in that same cycle.
- R10: A reset in mid-run clears the remembered bank. The start-up script selects bank 0 again, so a later request for the bank that was selected before the reset performs a bank-select write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_bank | input | BANK_W | Target register bank |
| req_offs | input | 4 | Target register offset within the window |
| req_data | input | DATA_W | Value to write |
| busy | output | 1 | Start-up script or request in progress |
| done | output | 1 | One-cycle pulse when a request's target write has finished |
| bus_addr | output | ADDR_W | Bus address |
| bus_data_o | output | DATA_W | Bus write data |
| bus_data_oe | output | 1 | Data bus drive enable, high for the whole of each write |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The hardest case to reach from the ports is a request that arrives while the start-up script is still running. The bench raises `req_valid` as soon as reset is released and keeps it high, and its expected-write queue then requires both script writes to come out before the request's write. A second hard case is the remembered bank being changed by a direct write to offset 0xE rather than by a bank-select write. The bench produces it with an offset-0xE request followed by a request for the bank just written, which must then produce no bank-select write. A reset issued between requests, followed by a request for the previously selected non-zero bank, shows that the remembered bank does not survive reset.

// File: rtl/bws_pkg.sv
package bws_pkg;

    typedef enum logic [2:0] {
        ST_BOOT_BANK,
        ST_BOOT_RX,
        ST_IDLE,
        ST_BANK,
        ST_TGT
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_e;

    localparam logic [3:0]  BANK_SEL_OFFS = 4'hE;
    localparam logic [3:0]  RX_CTRL_OFFS  = 4'h4;
    localparam logic [15:0] RX_ENABLE_VAL = 16'h0001;

endpackage

// File: rtl/bws_strobe.sv
module bws_strobe
    import bws_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_n_o,
    output logic              oe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              fin_o
);

    localparam int MAX_CYC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } stb_t;

    stb_t stb_d, stb_q;

    always_comb begin
        stb_d = stb_q;
        fin_o = 1'b0;
        case (stb_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    stb_d.ph   = PH_LOW;
                    stb_d.cnt  = '0;
                    stb_d.addr = addr_i;
                    stb_d.data = data_i;
                end
            end
            PH_LOW: begin
                if (stb_q.cnt == CNT_W'(LOW_CYC - 1)) begin
                    stb_d.ph  = PH_HIGH;
                    stb_d.cnt = '0;
                end else begin
                    stb_d.cnt = stb_q.cnt + CNT_W'(1);
                end
            end
            PH_HIGH: begin
                if (stb_q.cnt == CNT_W'(HIGH_CYC - 1)) begin
                    stb_d.ph  = PH_IDLE;
                    stb_d.cnt = '0;
                    fin_o     = 1'b1;
                end else begin
                    stb_d.cnt = stb_q.cnt + CNT_W'(1);
                end
            end
            default: stb_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= '0;
        else        stb_q <= stb_d;
    end

    assign wr_n_o = (stb_q.ph != PH_LOW);
    assign oe_o   = (stb_q.ph != PH_IDLE);
    assign addr_o = stb_q.addr;
    assign data_o = stb_q.data;

    // Run-length counter of the low phase, kept only for the checks below
    logic [CNT_W:0] lowlen_d, lowlen_q;
    assign lowlen_d = wr_n_o ? '0 : lowlen_q + (CNT_W+1)'(1);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lowlen_q <= '0;
        else        lowlen_q <= lowlen_d;
    end

    // R4
    low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> lowlen_q == (CNT_W+1)'(LOW_CYC));

    // R4
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n_o) |-> $past(!oe_o));

endmodule

// File: rtl/bws_bank_cache.sv
module bws_bank_cache #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [BANK_W-1:0] upd_bank_i,
    input  logic [BANK_W-1:0] look_bank_i,
    output logic              hit_o
);

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
    } cache_t;

    cache_t cache_d, cache_q;

    always_comb begin
        cache_d = cache_q;
        if (upd_i) begin
            cache_d.vld  = 1'b1;
            cache_d.bank = upd_bank_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cache_q <= '0;
        else        cache_q <= cache_d;
    end

    assign hit_o = cache_q.vld && (cache_q.bank == look_bank_i);

endmodule

// File: rtl/bank_wr_seq.sv
module bank_wr_seq
    import bws_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                BANK_W    = 3,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h300,
    parameter int                LOW_CYC   = 2,
    parameter int                HIGH_CYC  = 1,
    localparam int               OFFS_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [OFFS_W-1:0] req_offs,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe,
    output logic              bus_wr_n
);

    typedef struct packed {
        seq_state_e        st;
        logic              issue;
        logic [BANK_W-1:0] bank;
        logic [OFFS_W-1:0] offs;
        logic [DATA_W-1:0] data;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              start;
    logic              fin;
    logic [OFFS_W-1:0] wr_offs;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] wr_addr;
    logic              cache_upd;
    logic [BANK_W-1:0] cache_val;
    logic              bank_hit;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.issue = 1'b0;
        start      = seq_q.issue;
        wr_offs    = seq_q.offs;
        wr_data    = seq_q.data;
        cache_upd  = 1'b0;
        cache_val  = '0;
        case (seq_q.st)
            ST_BOOT_BANK: begin
                wr_offs = BANK_SEL_OFFS;
                wr_data = '0;
                if (fin) begin
                    cache_upd   = 1'b1;
                    cache_val   = '0;
                    seq_d.st    = ST_BOOT_RX;
                    seq_d.issue = 1'b1;
                end
            end
            ST_BOOT_RX: begin
                wr_offs = RX_CTRL_OFFS;
                wr_data = DATA_W'(RX_ENABLE_VAL);
                if (fin) seq_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.bank  = req_bank;
                    seq_d.offs  = req_offs;
                    seq_d.data  = req_data;
                    seq_d.issue = 1'b1;
                    if (req_offs == BANK_SEL_OFFS || bank_hit) seq_d.st = ST_TGT;
                    else                                        seq_d.st = ST_BANK;
                end
            end
            ST_BANK: begin
                wr_offs = BANK_SEL_OFFS;
                wr_data = DATA_W'(seq_q.bank);
                if (fin) begin
                    cache_upd   = 1'b1;
                    cache_val   = seq_q.bank;
                    seq_d.st    = ST_TGT;
                    seq_d.issue = 1'b1;
                end
            end
            ST_TGT: begin
                if (fin) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                    if (seq_q.offs == BANK_SEL_OFFS) begin
                        cache_upd = 1'b1;
                        cache_val = seq_q.data[BANK_W-1:0];
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.st    <= ST_BOOT_BANK;
            seq_q.issue <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wr_addr   = BASE_ADDR + ADDR_W'(wr_offs);
    assign req_ready = (seq_q.st == ST_IDLE);
    assign busy      = !req_ready;
    assign done      = seq_q.done;

    bws_bank_cache #(
        .BANK_W (BANK_W)
    ) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_i       (cache_upd),
        .upd_bank_i  (cache_val),
        .look_bank_i (req_bank),
        .hit_o       (bank_hit)
    );

    bws_strobe #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LOW_CYC  (LOW_CYC),
        .HIGH_CYC (HIGH_CYC)
    ) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .addr_i  (wr_addr),
        .data_i  (wr_data),
        .wr_n_o  (bus_wr_n),
        .oe_o    (bus_data_oe),
        .addr_o  (bus_addr),
        .data_o  (bus_data_o),
        .fin_o   (fin)
    );

    // Marks that no write has begun since reset, for the start-up check
    logic first_d, first_q;
    assign first_d = first_q && !(!bus_wr_n);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= first_d;
    end

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe && $past(bus_data_oe) |-> $stable(bus_addr) && $stable(bus_data_o));

    // R2
    first_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n) && first_q |-> bus_addr == BASE_ADDR + ADDR_W'(BANK_SEL_OFFS) && bus_data_o == '0);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy) && req_ready);

endmodule

// File: tb/sim_bank_wr_seq.sv
module sim_bank_wr_seq;

    localparam int LOWC  = 3;
    localparam int HIGHC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_bank = '0;
    logic [3:0]  req_offs = '0;
    logic [31:0] req_data = '0;
    logic        busy, done;
    logic [11:0] bus_addr;
    logic [31:0] bus_data_o;
    logic        bus_data_oe, bus_wr_n;

    always #2.5 clk = ~clk;

    bank_wr_seq #(
        .LOW_CYC  (LOWC),
        .HIGH_CYC (HIGHC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_offs(req_offs), .req_data(req_data),
        .busy(busy), .done(done), .bus_addr(bus_addr), .bus_data_o(bus_data_o),
        .bus_data_oe(bus_data_oe), .bus_wr_n(bus_wr_n)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard of expected bus writes
    logic [11:0] exp_a[$];
    logic [31:0] exp_d[$];
    string       exp_r[$];

    logic [2:0] m_bank;
    bit         m_vld;

    task automatic push(input logic [3:0] offs, input logic [31:0] d, input string r);
        exp_a.push_back(12'h300 + {8'h00, offs});
        exp_d.push_back(d);
        exp_r.push_back(r);
    endtask

    task automatic push_boot();
        push(4'hE, 32'h0, "R2");
        push(4'h4, 32'h1, "R2");
        m_bank = 3'd0;
        m_vld  = 1'b1;
    endtask

    // Monitor
    bit          prev_wr_n = 1'b1, prev_oe = 1'b0;
    int          low_n = 0, high_n = 0;
    logic [11:0] cur_a = '0;
    logic [31:0] cur_d = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_wr_n = 1'b1; prev_oe = 1'b0; low_n = 0; high_n = 0;
        end else begin
            if (req_ready)
                chk(bus_data_oe == 1'b0 && bus_wr_n == 1'b1, "R8", "ready during write",
                    {30'd0, bus_data_oe, bus_wr_n}, 32'h1);
            if (!bus_wr_n) begin
                if (prev_wr_n) begin
                    chk(prev_oe == 1'b0, "R4", "no idle gap before write", 32'(prev_oe), 32'h0);
                    cur_a = bus_addr; cur_d = bus_data_o; low_n = 1; high_n = 0;
                end else begin
                    low_n++;
                end
                chk(bus_addr == cur_a && bus_data_o == cur_d, "R4", "hold in low phase",
                    bus_data_o, cur_d);
            end else if (bus_data_oe) begin
                high_n++;
                chk(bus_addr == cur_a && bus_data_o == cur_d, "R4", "hold in high phase",
                    bus_data_o, cur_d);
            end else if (prev_oe) begin
                chk(low_n == LOWC, "R4", "low phase length", 32'(low_n), 32'(LOWC));
                chk(high_n == HIGHC, "R4", "high phase length", 32'(high_n), 32'(HIGHC));
                if (exp_a.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write addr", 32'(cur_a), 32'h0);
                end else begin
                    logic [11:0] ea;
                    logic [31:0] ed;
                    string       er;
                    ea = exp_a.pop_front(); ed = exp_d.pop_front(); er = exp_r.pop_front();
                    chk(cur_a == ea, {"R3 ", er}, "write address", 32'(cur_a), 32'(ea));
                    chk(cur_d == ed, er, "write data", cur_d, ed);
                end
            end
            prev_wr_n = bus_wr_n;
            prev_oe   = bus_data_oe;
        end
    end

    task automatic send(input logic [2:0] bank, input logic [3:0] offs, input logic [31:0] d);
        int n;
        if (offs == 4'hE) begin
            push(4'hE, d, "R7");
            m_bank = d[2:0]; m_vld = 1'b1;
        end else if (m_vld && m_bank == bank) begin
            push(offs, d, "R6");
        end else begin
            push(4'hE, 32'(bank), "R5");
            push(offs, d, "R5");
            m_bank = bank; m_vld = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b1; req_bank = bank; req_offs = offs; req_data = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8", "busy after accept", 32'(busy), 32'h1);
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R9", "done pulse seen", 32'(done), 32'h1);
        chk(req_ready == 1'b1, "R9", "ready with done", 32'(req_ready), 32'h1);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done lasts one cycle", 32'(done), 32'h0);
    endtask

    task automatic reset_phase();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus_wr_n == 1'b1, "R1", "strobe in reset", 32'(bus_wr_n), 32'h1);
        chk(bus_data_oe == 1'b0, "R1", "oe in reset", 32'(bus_data_oe), 32'h0);
        chk(req_ready == 1'b0, "R1", "ready in reset", 32'(req_ready), 32'h0);
        m_vld = 1'b0;
        push_boot();
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : driver
        reset_phase();
        // Request presented right after reset: held until the start-up script ends (R2, R8)
        send(3'd0, 4'h2, 32'hA5A5_0001);   // bank 0 already selected by script: R6
        send(3'd2, 4'h5, 32'h1234_5678);   // miss: R5
        send(3'd2, 4'hA, 32'hCAFE_F00D);   // hit: R6
        send(3'd0, 4'hE, 32'h0000_0003);   // direct bank write: R7
        send(3'd3, 4'h1, 32'h0BAD_BEEF);   // hit after direct write: R7
        send(3'd1, 4'h0, 32'hFFFF_FFFF);   // miss: R5
        send(3'd1, 4'hF, 32'h0000_0000);   // hit
        // Mid-run reset clears the remembered bank: R10
        reset_phase();
        send(3'd1, 4'h3, 32'h5555_AAAA);
        repeat (10) @(negedge clk);
        chk(exp_a.size() == 0, "R10", "pending expected writes", 32'(exp_a.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule